// File: doc/BRIEF.md
# Multi-Operand Carry-Save Summer

This block adds a fixed number of operands into one result in a single pass. Each operand slot has two compile-time flags. One marks the slot as two's-complement, so it is sign-extended to the result width. The other marks it as a minuend term, so it is taken away from the total instead of added to it. The result wraps modulo 2^W.

Subtracted operands enter the reduction bit-inverted. A single constant then adds back the +1 that each inversion lost; its value is the number of subtracted slots. Full-adder rows compress the operand set three vectors at a time. Only vectors at the shallowest ready depth are grouped, which keeps the logic depth logarithmic in the operand count. Once two vectors remain, one carry-propagate adder finishes the sum. An optional register stage, reset synchronously, can follow the adder.

Top module: `csa_sum_tree`

## Requirements
- R1: With no slot flagged, the result is the plain sum of all N operands, each zero-extended to W bits.
- R2: A slot whose bit in SIGNED_MASK is 1 is sign-extended from OPW to W bits before it is summed.
- R3: A slot whose bit in SUB_MASK is 1 is subtracted from the total instead of added.
- R4: With every slot subtracted, the result is the two's-complement negation of the operand sum, modulo 2^W.
- R5: Overflow wraps modulo 2^W. Eight 8-bit operands at 0xFF give 0xF8 at W=8.
- R6: With REG_OUT=1, the result for the operands presented before a rising edge appears on sum_o after that edge and holds while the operands are unchanged.
- R7: With REG_OUT=1, rst_i high at a rising edge makes sum_o zero after that edge.
- R8: The reduction ends with at most two vectors, and their sum equals the behavioural signed sum of the flagged operands.
- R9: With N=2, the block acts as a direct adder or subtractor, for example a minus b at W=9 when only slot 1 is subtracted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock for the optional output register |
| rst_i | input | 1 | Synchronous active-high reset of the output register |
| op_i | input | N*OPW | Operands; slot k occupies bits k*OPW to k*OPW+OPW-1 |
| sum_o | output | W | Result modulo 2^W |

## Verification
With the output register in place, every result is due exactly one rising edge after its operands are applied. The bench drives each new operand set on a falling edge. At the next falling edge it compares sum_o against the value its behavioural model computed for the previous set, so each comparison falls half a period after the edge that loaded the register. A reset cycle replaces the expected value with zero for that one slot. Four instances with different flag masks run in lockstep under the same timing.

// File: rtl/csa_sum_tree.sv
module csa_sum_tree #(
  parameter int N = 8,
  parameter int OPW = 8,
  parameter int W = 8,
  parameter logic [N-1:0] SIGNED_MASK = '0,
  parameter logic [N-1:0] SUB_MASK = '0,
  parameter bit REG_OUT = 1'b1
) (
  input  logic           clk_i,
  input  logic           rst_i,
  input  logic [N*OPW-1:0] op_i,
  output logic [W-1:0]   sum_o
);
  localparam int MAXV = N + 1;
  localparam int ITER = 2 * N + 4;
  localparam int NSUB = $countones(SUB_MASK);
  localparam logic [W-1:0] HI = {W{1'b1}} << OPW;
  localparam logic [W-1:0] COMP = W'(NSUB);

  logic [W-1:0] vec [MAXV];
  logic [W-1:0] nv [MAXV];
  int dep [MAXV];
  int nd [MAXV];
  int cnt;
  logic [W-1:0] comb_sum, ref_sum;

  always_comb begin
    int mind, m, nc, rn;
    logic [W-1:0] ra, rb, x;
    for (int i = 0; i < MAXV; i++) begin
      vec[i] = '0; dep[i] = 0; nv[i] = '0; nd[i] = 0;
    end
    ra = '0; rb = '0; x = '0; mind = 0; m = 0; nc = 0; rn = 0;
    for (int k = 0; k < N; k++) begin
      x = W'(op_i[k*OPW +: OPW]);
      if (SIGNED_MASK[k] && x[OPW-1]) x = x | HI;
      if (SUB_MASK[k]) x = ~x;
      vec[k] = x;
    end
    cnt = N;
    if (NSUB > 0) begin
      vec[N] = COMP;
      cnt = N + 1;
    end
    for (int it = 0; it < ITER; it++) begin
      if (cnt > 2) begin
        mind = 32'h7fff_ffff;
        for (int i = 0; i < MAXV; i++)
          if (i < cnt && dep[i] < mind) mind = dep[i];
        m = 0;
        for (int i = 0; i < MAXV; i++)
          if (i < cnt && dep[i] == mind) m++;
        if (m < 3) begin
          for (int i = 0; i < MAXV; i++)
            if (i < cnt && dep[i] == mind) dep[i] = mind + 1;
        end else begin
          nc = 0; rn = 0; ra = '0; rb = '0;
          for (int i = 0; i < MAXV; i++) begin
            nv[i] = '0; nd[i] = 0;
          end
          for (int i = 0; i < MAXV; i++) begin
            if (i < cnt) begin
              if (dep[i] != mind) begin
                nv[nc] = vec[i]; nd[nc] = dep[i]; nc++;
              end else if (rn == 0) begin
                ra = vec[i]; rn = 1;
              end else if (rn == 1) begin
                rb = vec[i]; rn = 2;
              end else begin
                nv[nc] = ra ^ rb ^ vec[i];
                nd[nc] = mind + 1;
                nv[nc+1] = ((ra & rb) | (ra & vec[i]) | (rb & vec[i])) << 1;
                nd[nc+1] = mind + 1;
                nc += 2; rn = 0;
              end
            end
          end
          if (rn >= 1) begin nv[nc] = ra; nd[nc] = mind; nc++; end
          if (rn == 2) begin nv[nc] = rb; nd[nc] = mind; nc++; end
          for (int i = 0; i < MAXV; i++) begin
            vec[i] = nv[i]; dep[i] = nd[i];
          end
          cnt = nc;
        end
      end
    end
    AST_TWO_ROWS_LEFT: assert (cnt <= 2); // R8
  end

  assign comb_sum = vec[0] + ((cnt > 1) ? vec[1] : '0);

  always_comb begin
    logic [W-1:0] y;
    ref_sum = '0;
    for (int k = 0; k < N; k++) begin
      y = W'(op_i[k*OPW +: OPW]);
      if (SIGNED_MASK[k] && y[OPW-1]) y = y | HI;
      ref_sum = SUB_MASK[k] ? ref_sum - y : ref_sum + y;
    end
  end

  AST_TREE_MATCHES_REF: assert property (@(posedge clk_i) disable iff (rst_i)
    comb_sum == ref_sum); // R8

  generate
    if (REG_OUT) begin : g_reg
      logic [W-1:0] sum_q;
      always_ff @(posedge clk_i) begin
        if (rst_i) sum_q <= '0;
        else sum_q <= comb_sum;
      end
      assign sum_o = sum_q;

      AST_ONE_CYCLE_LAG: assert property (@(posedge clk_i) disable iff (rst_i)
        $past(!rst_i) |-> sum_o == $past(comb_sum)); // R6
      AST_HOLD_STABLE: assert property (@(posedge clk_i) disable iff (rst_i)
        ($past(!rst_i) && $stable(op_i)) |=> $stable(sum_o)); // R6
    end else begin : g_comb
      assign sum_o = comb_sum;
    end
  endgenerate
endmodule

// File: tb/test_csa_sum_tree.sv
`timescale 1ns/1ps
module test_csa_sum_tree;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [63:0] op_a = '0;
  logic [29:0] op_b = '0;
  logic [31:0] op_c = '0;
  logic [15:0] op_d = '0;
  logic [7:0] sum_a, sum_c;
  logic [9:0] sum_b;
  logic [8:0] sum_d;
  int checks = 0, failures = 0;
  longint exp_a, exp_b, exp_c, exp_d;
  string tag_a, tag_b, tag_c, tag_d;
  bit have = 1'b0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  csa_sum_tree i_csa_sum_tree (.clk_i(clk), .rst_i(rst), .op_i(op_a), .sum_o(sum_a));
  csa_sum_tree #(.N(5), .OPW(6), .W(10), .SIGNED_MASK(5'b10101), .SUB_MASK(5'b01110))
    i_csa_sum_tree_mix (.clk_i(clk), .rst_i(rst), .op_i(op_b), .sum_o(sum_b));
  csa_sum_tree #(.N(4), .OPW(8), .W(8), .SIGNED_MASK(4'b0000), .SUB_MASK(4'b1111))
    i_csa_sum_tree_neg (.clk_i(clk), .rst_i(rst), .op_i(op_c), .sum_o(sum_c));
  csa_sum_tree #(.N(2), .OPW(8), .W(9), .SIGNED_MASK(2'b00), .SUB_MASK(2'b10))
    i_csa_sum_tree_two (.clk_i(clk), .rst_i(rst), .op_i(op_d), .sum_o(sum_d));

  function automatic longint model(int n, int opw, int w, int sgn, int sub, logic [63:0] ops);
    longint acc = 0;
    for (int k = 0; k < n; k++) begin
      longint v = longint'((ops >> (k * opw)) & ((64'd1 << opw) - 1));
      if (sgn[k] && v[opw-1]) v = v - (longint'(1) << opw);
      acc = sub[k] ? acc - v : acc + v;
    end
    return acc & ((longint'(1) << w) - 1);
  endfunction

  task automatic check(string tag, longint got, longint exp);
    checks++;
    if (got != exp) begin
      failures++;
      $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
    end
  endtask

  task automatic cyc(bit r, logic [63:0] va, logic [29:0] vb, logic [31:0] vc, logic [15:0] vd, string ta);
    @(negedge clk);
    if (have) begin
      check(tag_a, longint'(sum_a), exp_a);
      check(tag_b, longint'(sum_b), exp_b);
      check(tag_c, longint'(sum_c), exp_c);
      check(tag_d, longint'(sum_d), exp_d);
    end
    rst = r; op_a = va; op_b = vb; op_c = vc; op_d = vd;
    if (r) begin
      exp_a = 0; exp_b = 0; exp_c = 0; exp_d = 0;
      tag_a = "R7"; tag_b = "R7"; tag_c = "R7"; tag_d = "R7";
    end else begin
      exp_a = model(8, 8, 8, 0, 0, va);
      exp_b = model(5, 6, 10, 5'b10101, 5'b01110, 64'(vb));
      exp_c = model(4, 8, 8, 0, 4'b1111, 64'(vc));
      exp_d = model(2, 8, 9, 0, 2'b10, 64'(vd));
      tag_a = ta; tag_b = "R2 R3 R6"; tag_c = "R4 R6"; tag_d = "R9 R6";
    end
    have = 1'b1;
  endtask

  initial begin
    cyc(1'b1, '0, '0, '0, '0, "");
    cyc(1'b1, '0, '0, '0, '0, "");
    for (int i = 0; i < 150; i++)
      cyc(1'b0, {$urandom, $urandom}, 30'($urandom), $urandom, 16'($urandom), "R1 R6 R8");
    cyc(1'b0, {64{1'b1}}, {30{1'b1}}, {32{1'b1}}, 16'h00ff, "R5");
    cyc(1'b0, {64{1'b1}}, {30{1'b1}}, {32{1'b1}}, 16'h00ff, "R5 R6");
    cyc(1'b0, '0, '0, '0, '0, "R1");
    cyc(1'b0, {8{8'h80}}, {5{6'h20}}, 32'h0000_0001, 16'hff00, "R1");
    cyc(1'b0, {8{8'h01}}, {5{6'h1f}}, 32'h8080_8080, 16'h0102, "R1");
    cyc(1'b1, {8{8'h11}}, {5{6'h11}}, 32'h1111_1111, 16'h1111, "");
    cyc(1'b0, {8{8'h11}}, {5{6'h11}}, 32'h1111_1111, 16'h1111, "R1 R6");
    for (int i = 0; i < 20; i++)
      cyc(1'b0, {$urandom, $urandom}, 30'($urandom), $urandom, 16'($urandom), "R1 R8");
    cyc(1'b0, '0, '0, '0, '0, "R1");
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #20000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule